// File: doc/BRIEF.md
# Flash page program sequencer

The sequencer writes one page of 32 bytes into an on-block model of a flash array. A host first raises the software enable. Once that enable has been held for a settling time, the host stores page bytes into a 32-slot latch through a byte-write port. Any slot the host leaves unwritten holds 0xFF, so a short page needs no filler writes. The host then issues a start command with a page start address.

The start is checked in a fixed priority order: page alignment first, then the hardware write-enable input, then whether the target page is fully erased. A rejected start raises a single error flag and changes nothing. An accepted start arms an overrun watchdog and raises the setup strobe. After a fixed setup delay the program strobe follows, for a pulse of fixed length. At the end of the pulse the latch contents go into the array and a one-cycle done pulse is given.

The watchdog aborts the sequence if it runs too long. Losing the hardware write enable during a sequence also aborts it. While a sequence is in progress, reads of the array are blocked. All delays are given in microseconds and turned into clock cycles through a clock-frequency parameter.

Top module: `flash_page_prog`

## Requirements
- R1: A latch write (wr_en with wr_idx, wr_data) takes effect only once swe has been sampled high on SETTLE_CYC = 10*CLK_MHZ consecutive clock edges. A write made earlier, or made while swe is low, is ignored. Dropping swe restarts the settling count.
- R2: Every latch slot not written since the last completed sequence holds 0xFF. After a completed sequence, all 32 slots return to 0xFF.
- R3: A start whose start_addr has any of its low 5 bits nonzero (the address is not a multiple of 0x20) is rejected. The rejection sets align_error, and busy stays low.
- R4: A start made while fwe is 0 is rejected with fwe_error. If fwe is sampled 0 during a sequence, the sequence aborts at that edge: busy, setup_strobe and prog_strobe fall together, fwe_error is set, and the array is left unchanged.
- R5: A start to a page that holds any byte other than 0xFF is rejected with not_erased_error. When several checks fail, only one flag is raised, in the order alignment, then fwe, then erased state.
- R6: An accepted start raises busy and setup_strobe in the following cycle. prog_strobe rises exactly SETUP_CYC = 50*CLK_MHZ cycles after the accepting edge, and setup_strobe stays high throughout.
- R7: prog_strobe stays high for exactly PULSE_CYC = 500*CLK_MHZ cycles. On the edge that ends the pulse, the page is written with the latch bytes (slot i to page base + i). At that same edge done pulses for one cycle, and busy and both strobes fall.
- R8: If the sequence has not ended WDT_CYC = WDT_US*CLK_MHZ cycles after the accepting edge, it aborts at that edge. The abort sets wdt_abort, drops both strobes and busy in the same cycle, gives no done pulse and leaves the array unchanged.
- R9: rd_data and rd_ok reflect rd_addr one cycle later. rd_ok is 0 and rd_data is 0x00 in the cycle after any cycle in which busy was high.
- R10: Error flags hold until the next start command that is not ignored. That command clears them all. A start is ignored while busy is high or while the R1 settling has not completed.
- R11: After reset, every array byte reads 0xFF, busy and done are low, and all error flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| swe | input | 1 | Software write enable; gates page loading after settling |
| fwe | input | 1 | Hardware write enable; required for programming |
| wr_en | input | 1 | Latch byte write strobe |
| wr_idx | input | 5 | Latch slot index |
| wr_data | input | 8 | Latch byte value |
| start | input | 1 | Start command |
| start_addr | input | ADDR_W | Page start byte address |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | 8 | Array read data, one cycle after rd_addr |
| rd_ok | output | 1 | Read data valid (low while blocked) |
| busy | output | 1 | Sequence in progress |
| setup_strobe | output | 1 | Program setup strobe to the array |
| prog_strobe | output | 1 | Program pulse strobe to the array |
| done | output | 1 | One-cycle pulse on completion |
| align_error | output | 1 | Last start was misaligned |
| fwe_error | output | 1 | Hardware enable missing at start or lost during the sequence |
| not_erased_error | output | 1 | Target page was not erased |
| wdt_abort | output | 1 | Sequence aborted by the watchdog |

## Verification
Every result is counted in clock edges from the edge that samples its stimulus. Error flags appear one edge after the start edge. prog_strobe rises SETUP_CYC edges after the accepting edge, and done comes SETUP_CYC+PULSE_CYC edges after it. A watchdog or write-enable abort lands exactly on its edge. Read data arrives one edge after the address, and rd_ok trails busy by one edge. The bench drives and samples only on falling edges, and it compares outputs against these edge counts at every falling edge of each sequence. It also sweeps all start addresses for alignment and reads back the whole array against a model it keeps itself.

// File: rtl/fpp_pkg.sv
package fpp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_PULSE = 2'd2
    } seq_state_e;

    function automatic int unsigned us_to_cycles(int unsigned us, int unsigned mhz);
        return us * mhz;
    endfunction

endpackage

// File: rtl/fpp_settle.sv
module fpp_settle #(
    parameter int unsigned SETTLE_CYC = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic swe,
    output logic ready
);
    localparam int unsigned CW = $clog2(SETTLE_CYC + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } settle_t;

    settle_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!swe) begin
            s_d.cnt = '0;
        end else if (s_q.cnt != CW'(SETTLE_CYC)) begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ready = (s_q.cnt == CW'(SETTLE_CYC));
endmodule

// File: rtl/fpp_latch.sv
module fpp_latch #(
    parameter int unsigned PAGE_BYTES = 32
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [$clog2(PAGE_BYTES)-1:0]     wr_idx,
    input  logic [7:0]                        wr_data,
    input  logic                              clear,
    output logic [PAGE_BYTES*8-1:0]           page_data
);
    typedef struct packed {
        logic [PAGE_BYTES*8-1:0] bytes;
    } latch_t;

    latch_t l_d, l_q;

    always_comb begin
        l_d = l_q;
        if (clear) begin
            l_d.bytes = '1;
        end else if (wr_en) begin
            l_d.bytes[wr_idx*8 +: 8] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) l_q <= '1;
        else        l_q <= l_d;
    end

    assign page_data = l_q.bytes;
endmodule

// File: rtl/fpp_array.sv
module fpp_array #(
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned PAGE_BYTES = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         commit,
    input  logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] commit_page,
    input  logic [PAGE_BYTES*8-1:0]      page_data,
    input  logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] chk_page,
    output logic                         chk_erased,
    input  logic [ADDR_W-1:0]            rd_addr,
    input  logic                         rd_block,
    output logic [7:0]                   rd_data,
    output logic                         rd_ok
);
    localparam int unsigned IDX_W = $clog2(PAGE_BYTES);
    localparam int unsigned DEPTH = 2 ** ADDR_W;

    typedef struct packed {
        logic [7:0] data;
        logic       ok;
    } rd_t;

    logic [7:0] mem_d [DEPTH];
    logic [7:0] mem_q [DEPTH];
    rd_t        r_d, r_q;

    always_comb begin
        for (int a = 0; a < DEPTH; a++) mem_d[a] = mem_q[a];
        if (commit) begin
            for (int i = 0; i < PAGE_BYTES; i++) begin
                mem_d[{commit_page, IDX_W'(i)}] = page_data[i*8 +: 8];
            end
        end
        r_d.ok   = !rd_block;
        r_d.data = rd_block ? 8'h00 : mem_q[rd_addr];
    end

    always_comb begin
        chk_erased = 1'b1;
        for (int i = 0; i < PAGE_BYTES; i++) begin
            if (mem_q[{chk_page, IDX_W'(i)}] != 8'hFF) chk_erased = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < DEPTH; a++) mem_q[a] <= 8'hFF;
            r_q <= '0;
        end else begin
            for (int a = 0; a < DEPTH; a++) mem_q[a] <= mem_d[a];
            r_q <= r_d;
        end
    end

    assign rd_data = r_q.data;
    assign rd_ok   = r_q.ok;
endmodule

// File: rtl/fpp_seq.sv
module fpp_seq
    import fpp_pkg::*;
#(
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned PAGE_BYTES = 32,
    parameter int unsigned SETUP_CYC  = 1000,
    parameter int unsigned PULSE_CYC  = 10000,
    parameter int unsigned WDT_CYC    = 132000
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic [ADDR_W-1:0]            start_addr,
    input  logic                         fwe,
    input  logic                         load_ready,
    input  logic                         page_erased,
    output logic                         busy,
    output logic                         setup_strobe,
    output logic                         prog_strobe,
    output logic                         done,
    output logic                         align_error,
    output logic                         fwe_error,
    output logic                         not_erased_error,
    output logic                         wdt_abort,
    output logic                         commit,
    output logic                         finish,
    output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] page
);
    localparam int unsigned IDX_W = $clog2(PAGE_BYTES);
    localparam int unsigned PG_W  = ADDR_W - IDX_W;
    localparam int unsigned MAXC  = (PULSE_CYC > SETUP_CYC) ? PULSE_CYC : SETUP_CYC;
    localparam int unsigned CNT_W = $clog2(MAXC + 1);
    localparam int unsigned WDT_W = $clog2(WDT_CYC + 1);

    typedef struct packed {
        seq_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic [WDT_W-1:0] wdt;
        logic [PG_W-1:0]  page;
        logic             done;
        logic             align_e;
        logic             fwe_e;
        logic             erase_e;
        logic             wdt_e;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        commit   = 1'b0;
        finish   = 1'b0;
        case (s_q.state)
            ST_IDLE: begin
                if (start && load_ready) begin
                    s_d.align_e = 1'b0;
                    s_d.fwe_e   = 1'b0;
                    s_d.erase_e = 1'b0;
                    s_d.wdt_e   = 1'b0;
                    if (start_addr[IDX_W-1:0] != '0) begin
                        s_d.align_e = 1'b1;
                    end else if (!fwe) begin
                        s_d.fwe_e = 1'b1;
                    end else if (!page_erased) begin
                        s_d.erase_e = 1'b1;
                    end else begin
                        s_d.state = ST_SETUP;
                        s_d.cnt   = '0;
                        s_d.wdt   = '0;
                        s_d.page  = start_addr[ADDR_W-1:IDX_W];
                    end
                end
            end
            default: begin
                if (s_q.wdt == WDT_W'(WDT_CYC - 1)) begin
                    s_d.state = ST_IDLE;
                    s_d.wdt_e = 1'b1;
                    finish    = 1'b1;
                end else if (!fwe) begin
                    s_d.state = ST_IDLE;
                    s_d.fwe_e = 1'b1;
                    finish    = 1'b1;
                end else begin
                    s_d.wdt = s_q.wdt + 1'b1;
                    if (s_q.state == ST_SETUP) begin
                        if (s_q.cnt == CNT_W'(SETUP_CYC - 1)) begin
                            s_d.state = ST_PULSE;
                            s_d.cnt   = '0;
                        end else begin
                            s_d.cnt = s_q.cnt + 1'b1;
                        end
                    end else begin
                        if (s_q.cnt == CNT_W'(PULSE_CYC - 1)) begin
                            s_d.state = ST_IDLE;
                            s_d.done  = 1'b1;
                            commit    = 1'b1;
                            finish    = 1'b1;
                        end else begin
                            s_d.cnt = s_q.cnt + 1'b1;
                        end
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.state <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy             = (s_q.state != ST_IDLE);
    assign setup_strobe     = busy;
    assign prog_strobe      = (s_q.state == ST_PULSE);
    assign done             = s_q.done;
    assign align_error      = s_q.align_e;
    assign fwe_error        = s_q.fwe_e;
    assign not_erased_error = s_q.erase_e;
    assign wdt_abort        = s_q.wdt_e;
    assign page             = s_q.page;
endmodule

// File: rtl/flash_page_prog.sv
module flash_page_prog
    import fpp_pkg::*;
#(
    parameter int unsigned CLK_MHZ    = 20,
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned PAGE_BYTES = 32,
    parameter int unsigned WDT_US     = 6600
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          swe,
    input  logic                          fwe,
    input  logic                          wr_en,
    input  logic [$clog2(PAGE_BYTES)-1:0] wr_idx,
    input  logic [7:0]                    wr_data,
    input  logic                          start,
    input  logic [ADDR_W-1:0]             start_addr,
    input  logic [ADDR_W-1:0]             rd_addr,
    output logic [7:0]                    rd_data,
    output logic                          rd_ok,
    output logic                          busy,
    output logic                          setup_strobe,
    output logic                          prog_strobe,
    output logic                          done,
    output logic                          align_error,
    output logic                          fwe_error,
    output logic                          not_erased_error,
    output logic                          wdt_abort
);
    localparam int unsigned IDX_W      = $clog2(PAGE_BYTES);
    localparam int unsigned PG_W       = ADDR_W - IDX_W;
    localparam int unsigned SETTLE_CYC = us_to_cycles(10, CLK_MHZ);
    localparam int unsigned SETUP_CYC  = us_to_cycles(50, CLK_MHZ);
    localparam int unsigned PULSE_CYC  = us_to_cycles(500, CLK_MHZ);
    localparam int unsigned WDT_CYC    = us_to_cycles(WDT_US, CLK_MHZ);

    logic                    load_ready;
    logic                    page_erased;
    logic                    commit;
    logic                    finish;
    logic [PG_W-1:0]         commit_page;
    logic [PAGE_BYTES*8-1:0] page_data;

    fpp_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
        .clk   (clk),
        .rst_n (rst_n),
        .swe   (swe),
        .ready (load_ready)
    );

    fpp_latch #(.PAGE_BYTES(PAGE_BYTES)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en && load_ready && !busy),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .clear     (finish),
        .page_data (page_data)
    );

    fpp_array #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_array (
        .clk         (clk),
        .rst_n       (rst_n),
        .commit      (commit),
        .commit_page (commit_page),
        .page_data   (page_data),
        .chk_page    (start_addr[ADDR_W-1:IDX_W]),
        .chk_erased  (page_erased),
        .rd_addr     (rd_addr),
        .rd_block    (busy),
        .rd_data     (rd_data),
        .rd_ok       (rd_ok)
    );

    fpp_seq #(
        .ADDR_W     (ADDR_W),
        .PAGE_BYTES (PAGE_BYTES),
        .SETUP_CYC  (SETUP_CYC),
        .PULSE_CYC  (PULSE_CYC),
        .WDT_CYC    (WDT_CYC)
    ) u_seq (
        .clk              (clk),
        .rst_n            (rst_n),
        .start            (start),
        .start_addr       (start_addr),
        .fwe              (fwe),
        .load_ready       (load_ready),
        .page_erased      (page_erased),
        .busy             (busy),
        .setup_strobe     (setup_strobe),
        .prog_strobe      (prog_strobe),
        .done             (done),
        .align_error      (align_error),
        .fwe_error        (fwe_error),
        .not_erased_error (not_erased_error),
        .wdt_abort        (wdt_abort),
        .commit           (commit),
        .finish           (finish),
        .page             (commit_page)
    );
endmodule

// File: rtl/fpp_checker.sv
module fpp_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       fwe,
    input logic       busy,
    input logic       setup_strobe,
    input logic       prog_strobe,
    input logic       done,
    input logic       rd_ok,
    input logic [7:0] rd_data,
    input logic       align_error,
    input logic       fwe_error,
    input logic       not_erased_error,
    input logic       wdt_abort
);
    p_pulse_from_setup_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prog_strobe) |-> $past(setup_strobe));

    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !prog_strobe && !setup_strobe));

    p_fwe_loss_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !fwe) |=> (!busy && !prog_strobe && fwe_error));

    p_wdt_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdt_abort) |-> (!setup_strobe && !prog_strobe && !done));

    p_read_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!rd_ok && rd_data == 8'h00));

    p_one_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({align_error, fwe_error, not_erased_error, wdt_abort}));

    p_flags_clear_run_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !(align_error || fwe_error || not_erased_error || wdt_abort));
endmodule

bind flash_page_prog fpp_checker u_fpp_checker (
    .clk              (clk),
    .rst_n            (rst_n),
    .fwe              (fwe),
    .busy             (busy),
    .setup_strobe     (setup_strobe),
    .prog_strobe      (prog_strobe),
    .done             (done),
    .rd_ok            (rd_ok),
    .rd_data          (rd_data),
    .align_error      (align_error),
    .fwe_error        (fwe_error),
    .not_erased_error (not_erased_error),
    .wdt_abort        (wdt_abort)
);

// File: tb/test_flash_page_prog.sv
module test_flash_page_prog;
    localparam int SETTLE = 10;
    localparam int SETUP  = 50;
    localparam int PULSE  = 500;
    localparam int WDT_B  = 400;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       swe [2];
    logic       fwe [2];
    logic       wr_en [2];
    logic [4:0] wr_idx [2];
    logic [7:0] wr_data [2];
    logic       start [2];
    logic [7:0] start_addr [2];
    logic [7:0] rd_addr [2];
    logic [7:0] rd_data [2];
    logic       rd_ok [2];
    logic       busy [2];
    logic       setup_strobe [2];
    logic       prog_strobe [2];
    logic       done [2];
    logic       align_error [2];
    logic       fwe_error [2];
    logic       not_erased_error [2];
    logic       wdt_abort [2];

    int nchk = 0;
    int nerr = 0;
    logic [7:0] exp_mem [2][256];

    always #5 clk = ~clk;

    flash_page_prog #(.CLK_MHZ(1)) i_flash_page_prog (
        .clk(clk), .rst_n(rst_n), .swe(swe[0]), .fwe(fwe[0]),
        .wr_en(wr_en[0]), .wr_idx(wr_idx[0]), .wr_data(wr_data[0]),
        .start(start[0]), .start_addr(start_addr[0]), .rd_addr(rd_addr[0]),
        .rd_data(rd_data[0]), .rd_ok(rd_ok[0]), .busy(busy[0]),
        .setup_strobe(setup_strobe[0]), .prog_strobe(prog_strobe[0]), .done(done[0]),
        .align_error(align_error[0]), .fwe_error(fwe_error[0]),
        .not_erased_error(not_erased_error[0]), .wdt_abort(wdt_abort[0])
    );

    flash_page_prog #(.CLK_MHZ(1), .WDT_US(WDT_B)) i_flash_page_prog_wdt (
        .clk(clk), .rst_n(rst_n), .swe(swe[1]), .fwe(fwe[1]),
        .wr_en(wr_en[1]), .wr_idx(wr_idx[1]), .wr_data(wr_data[1]),
        .start(start[1]), .start_addr(start_addr[1]), .rd_addr(rd_addr[1]),
        .rd_data(rd_data[1]), .rd_ok(rd_ok[1]), .busy(busy[1]),
        .setup_strobe(setup_strobe[1]), .prog_strobe(prog_strobe[1]), .done(done[1]),
        .align_error(align_error[1]), .fwe_error(fwe_error[1]),
        .not_erased_error(not_erased_error[1]), .wdt_abort(wdt_abort[1])
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    function automatic logic [7:0] pat(int p, int i);
        return 8'((p * 37 + i * 11 + 5) & 255);
    endfunction

    function automatic logic [3:0] flags(int u);
        return {align_error[u], fwe_error[u], not_erased_error[u], wdt_abort[u]};
    endfunction

    task automatic settle(int u);
        swe[u] = 1'b1;
        repeat (SETTLE + 2) tick();
    endtask

    task automatic put(int u, int idx, logic [7:0] d);
        wr_en[u] = 1'b1; wr_idx[u] = 5'(idx); wr_data[u] = d;
        tick();
        wr_en[u] = 1'b0;
    endtask

    task automatic cmd(int u, int addr);
        start[u] = 1'b1; start_addr[u] = 8'(addr);
        tick();
        start[u] = 1'b0;
    endtask

    // Checks a sequence edge by edge; n counts edges after the accepting one.
    task automatic run_seq(string req, int u, int end_n, bit aborted, int drop_at);
        for (int n = 0; n <= end_n; n++) begin
            logic b, pr, dn, ok;
            b  = (n < end_n);
            pr = b && (n >= SETUP);
            dn = (n == end_n) && !aborted;
            ok = !(n >= 1 && n <= end_n);
            chk(req, {busy[u], setup_strobe[u], prog_strobe[u], done[u], rd_ok[u]},
                {b, b, pr, dn, ok});
            if (!ok) chk("R9", rd_data[u], 8'h00);
            if (n == drop_at) fwe[u] = 1'b0;
            if (n < end_n) tick();
        end
    endtask

    task automatic read_page(string req, int u, int p);
        for (int i = 0; i < 32; i++) begin
            rd_addr[u] = 8'(p * 32 + i);
            tick();
            chk(req, {rd_ok[u], rd_data[u]}, {1'b1, exp_mem[u][p * 32 + i]});
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        for (int u = 0; u < 2; u++) begin
            swe[u] = 0; fwe[u] = 1; wr_en[u] = 0; wr_idx[u] = 0; wr_data[u] = 0;
            start[u] = 0; start_addr[u] = 0; rd_addr[u] = 0;
            for (int a = 0; a < 256; a++) exp_mem[u][a] = 8'hFF;
        end
        repeat (4) tick();
        for (int u = 0; u < 2; u++)
            chk("R11 reset", {busy[u], done[u], flags(u)}, 6'b0);
        rst_n = 1'b1;
        tick();
        for (int p = 0; p < 8; p++) read_page("R11 erased", 0, p);

        // R3: sweep every start address
        settle(0);
        for (int a = 0; a < 256; a++) begin
            if (a % 32 != 0) begin
                cmd(0, a);
                chk("R3 align", {busy[0], flags(0)}, {1'b0, 4'b1000});
            end
        end

        // R10: start ignored while not settled; flags held
        swe[0] = 1'b0;
        tick();
        cmd(0, 0);
        chk("R10 ignored start", {busy[0], flags(0)}, {1'b0, 4'b1000});
        settle(0);

        // R6 R7: full pages 0..6
        for (int p = 0; p < 7; p++) begin
            for (int i = 0; i < 32; i++) put(0, i, pat(p, i));
            cmd(0, p * 32);
            chk("R10 flags cleared", flags(0), 4'b0);
            run_seq("R6 R7 timing", 0, SETUP + PULSE, 1'b0, -1);
            for (int i = 0; i < 32; i++) exp_mem[0][p * 32 + i] = pat(p, i);
        end

        // R1 R2: early write ignored, odd slots padded, latch cleared after page 6
        swe[0] = 1'b0;
        tick();
        swe[0] = 1'b1;
        put(0, 0, 8'h00);
        repeat (SETTLE + 2) tick();
        for (int i = 2; i < 32; i += 2) put(0, i, pat(7, i));
        cmd(0, 7 * 32);
        run_seq("R7 timing", 0, SETUP + PULSE, 1'b0, -1);
        for (int i = 2; i < 32; i += 2) exp_mem[0][7 * 32 + i] = pat(7, i);
        for (int p = 0; p < 8; p++) read_page("R1 R2 R7 readback", 0, p);

        // R5: erased check and priority
        cmd(0, 3 * 32);
        chk("R5 not erased", {busy[0], flags(0)}, {1'b0, 4'b0010});
        fwe[0] = 1'b0;
        cmd(0, 3 * 32);
        chk("R5 fwe before erased", flags(0), 4'b0100);
        cmd(0, 8'h61);
        chk("R5 align first", flags(0), 4'b1000);
        fwe[0] = 1'b1;

        // R8: watchdog abort on the short-watchdog instance
        settle(1);
        for (int i = 0; i < 32; i++) put(1, i, pat(9, i));
        cmd(1, 0);
        run_seq("R8 wdt abort", 1, WDT_B, 1'b1, -1);
        chk("R8 flag", flags(1), 4'b0001);
        read_page("R8 array untouched", 1, 0);

        // R4: fwe at start and during the sequence
        fwe[1] = 1'b0;
        cmd(1, 32);
        chk("R4 fwe at start", {busy[1], flags(1)}, {1'b0, 4'b0100});
        fwe[1] = 1'b1;
        for (int i = 0; i < 32; i++) put(1, i, pat(10, i));
        cmd(1, 32);
        run_seq("R4 fwe loss", 1, 101, 1'b1, 100);
        chk("R4 flag", flags(1), 4'b0100);
        fwe[1] = 1'b1;
        read_page("R4 array untouched", 1, 1);

        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule